// File: doc/BRIEF.md
# Two-Bit Slice Byte Return Port

This block is the device side of a narrow return path. Bytes that the device wants to hand to a host are written into a small transmit queue. The host sees them through two status lines only, one carrying the low bit of a 2-bit slice and one carrying the high bit. A byte-available flag tells the host that the head of the queue holds data. An interrupt request, gated by a host-owned enable bit, prompts the host to start reading.

The host reads one byte with four read strobes. While a strobe is asserted the two lines show the current slice. Releasing the strobe moves the block to the next slice. When the fourth strobe is released the byte leaves the queue. If another byte is queued, byte-available stays high and the host can read again without leaving its interrupt handler. A free-running timer also raises the interrupt at a fixed interval while the enable is set. Byte-available stays low for that interrupt, so the host can tell that no data came with it.

The read strobe is asynchronous to the device clock and is synchronised inside the block. The enable bit is taken as synchronous to the device clock.

Top module: `slice_tx_port`

## Requirements
- R1: After reset, byte_avail, irq, slice_lo and slice_hi are all 0 and wr_ready is 1.
- R2: byte_avail is 1 exactly when the queue holds at least one byte. While the queue is empty, slice_lo and slice_hi are 0.
- R3: For the head byte, slice_lo and slice_hi show bits [1:0] first, with slice_lo on bit 0 and slice_hi on bit 1. Each release of the read strobe moves to the next slice: bits [3:2], then [5:4], then [7:6]. A slice stays unchanged while no release occurs.
- R4: The release of the fourth strobe removes the head byte. Slice [1:0] of the next byte then appears, and byte_avail stays 1 when another byte was queued and goes to 0 otherwise.
- R5: Read strobes while the queue is empty have no effect. A byte written afterwards starts at slice [1:0].
- R6: When the queue holds DEPTH bytes, wr_ready is 0 and a write is dropped. The bytes already held come out unchanged and in order.
- R7: With irq_en high, irq rises while a byte is available and no read has started. It falls at the first strobe assertion and stays low while the host keeps reading queued bytes. It rises again when a byte arrives after the queue has drained.
- R8: With irq_en low, irq stays 0 even with bytes queued or periodic intervals elapsing. Raising irq_en then shows a pending data request at once.
- R9: With irq_en high, irq rises every TICK_CYCLES clock cycles, counted from the cycle the enable is sampled high, and byte_avail stays 0 for that interrupt. A strobe assertion clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Write a byte into the transmit queue |
| wr_data | input | DATA_W | Byte to queue |
| wr_ready | output | 1 | Queue has room |
| host_rd | input | 1 | Host read strobe, active high, asynchronous |
| irq_en | input | 1 | Host interrupt enable |
| slice_lo | output | 1 | Low bit of the current slice |
| slice_hi | output | 1 | High bit of the current slice |
| byte_avail | output | 1 | A byte is waiting |
| irq | output | 1 | Interrupt request level |

## Verification
A queue write shows up on byte_avail, the slice lines and irq in the cycle after the clock edge that takes it. The bench samples those outputs on the following falling edge. A strobe edge passes through two synchroniser stages and one edge-detect register, so its effect on the slice lines, the queue and irq appears three rising edges after the strobe changes. The bench holds each strobe level for four cycles and samples at a falling edge after that. The periodic interrupt is checked at half an interval after enabling, when irq must still be low, and again a few cycles past the full TICK_CYCLES, when it must be high.

// File: rtl/slice_tx_pkg.sv
package slice_tx_pkg;

   typedef enum logic {
      ORDER_LSB_FIRST = 1'b0,
      ORDER_MSB_FIRST = 1'b1
   } slice_order_e;

   localparam int unsigned SLICE_W = 2;

endpackage

// File: rtl/slice_tx_sync.sv
module slice_tx_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic sync_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("slice_tx_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], async_i};
      end
   end

   assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/slice_tx_fifo.sv
module slice_tx_fifo #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_i,
   input  logic [DATA_W-1:0] push_data_i,
   input  logic              pop_i,
   output logic [DATA_W-1:0] head_o,
   output logic              empty_o,
   output logic              full_o
);

   localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CW = AW + 1;

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("slice_tx_fifo: DEPTH must be a power of two, at least 2");
   end

   logic [DATA_W-1:0] mem_q [DEPTH];
   logic [AW-1:0]     wptr_q, rptr_q;
   logic [CW-1:0]     count_q;
   logic              push_ok, pop_ok;

   assign full_o  = (count_q == CW'(DEPTH));
   assign empty_o = (count_q == '0);
   assign push_ok = push_i && !full_o;
   assign pop_ok  = pop_i && !empty_o;
   assign head_o  = mem_q[rptr_q];

   always_ff @(posedge clk) begin
      if (push_ok) begin
         mem_q[wptr_q] <= push_data_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr_q  <= '0;
         rptr_q  <= '0;
         count_q <= '0;
      end else begin
         if (push_ok) wptr_q <= wptr_q + 1'b1;
         if (pop_ok)  rptr_q <= rptr_q + 1'b1;
         case ({push_ok, pop_ok})
            2'b10:   count_q <= count_q + 1'b1;
            2'b01:   count_q <= count_q - 1'b1;
            default: count_q <= count_q;
         endcase
      end
   end

   // R6: a write into a full queue without a pop leaves the fill level alone
   a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (full_o && push_i && !pop_i) |=> $stable(count_q));

   // R5: the serializer never asks for a pop from an empty queue
   a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      pop_i |-> (count_q != '0));

endmodule

// File: rtl/slice_tx_tick.sv
module slice_tx_tick #(
   parameter int unsigned TICK_CYCLES = 12800
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable_i,
   input  logic ack_i,
   output logic pend_o
);

   localparam int unsigned CW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;

   if (TICK_CYCLES < 2) begin : g_bad_tick
      $error("slice_tx_tick: TICK_CYCLES must be at least 2");
   end

   logic [CW-1:0] cnt_q;
   logic          wrap;

   assign wrap = enable_i && (cnt_q == CW'(TICK_CYCLES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         pend_o <= 1'b0;
      end else if (!enable_i) begin
         cnt_q  <= '0;
         pend_o <= 1'b0;
      end else begin
         cnt_q <= wrap ? '0 : cnt_q + 1'b1;
         if (wrap)       pend_o <= 1'b1;
         else if (ack_i) pend_o <= 1'b0;
      end
   end

   // R8: no periodic request is held while interrupts are disabled
   a_r8_tick_masked: assert property (@(posedge clk) disable iff (!rst_n)
      !enable_i |=> !pend_o);

   // R9: a pending tick is only ever raised by a completed interval
   a_r9_tick_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_o) |-> $past(enable_i));

endmodule

// File: rtl/slice_tx_port.sv
module slice_tx_port #(
   parameter int unsigned                 DATA_W      = 8,
   parameter int unsigned                 DEPTH       = 8,
   parameter int unsigned                 SYNC_STAGES = 2,
   parameter int unsigned                 TICK_CYCLES = 12800,
   parameter slice_tx_pkg::slice_order_e ORDER       = slice_tx_pkg::ORDER_LSB_FIRST
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_ready,
   input  logic              host_rd,
   input  logic              irq_en,
   output logic              slice_lo,
   output logic              slice_hi,
   output logic              byte_avail,
   output logic              irq
);

   localparam int unsigned SW   = slice_tx_pkg::SLICE_W;
   localparam int unsigned NSL  = DATA_W / SW;
   localparam int unsigned IW   = (NSL > 1) ? $clog2(NSL) : 1;
   localparam int unsigned LAST = NSL - 1;

   if (DATA_W < SW || (DATA_W % SW) != 0) begin : g_bad_width
      $error("slice_tx_port: DATA_W must be a multiple of the slice width");
   end

   logic              rd_s, rd_prev_q, rd_rise, rd_fall;
   logic [DATA_W-1:0] head;
   logic              empty, full;
   logic              advance, pop;
   logic [IW-1:0]     idx_q;
   logic              serving_q;
   logic              tick_pend;
   logic [SW-1:0]     slices [NSL];
   logic [SW-1:0]     cur_slice;

   slice_tx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (host_rd),
      .sync_o  (rd_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_prev_q <= 1'b0;
      else        rd_prev_q <= rd_s;
   end

   assign rd_rise = rd_s && !rd_prev_q;
   assign rd_fall = !rd_s && rd_prev_q;

   slice_tx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk         (clk),
      .rst_n       (rst_n),
      .push_i      (wr_valid),
      .push_data_i (wr_data),
      .pop_i       (pop),
      .head_o      (head),
      .empty_o     (empty),
      .full_o      (full)
   );

   assign wr_ready   = !full;
   assign byte_avail = !empty;
   assign advance    = rd_fall && !empty;
   assign pop        = advance && (idx_q == IW'(LAST));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
      end else if (pop) begin
         idx_q <= '0;
      end else if (advance) begin
         idx_q <= idx_q + 1'b1;
      end
   end

   // Slice table of the head byte, ordered by the chosen variant.
   for (genvar s = 0; s < NSL; s++) begin : g_slice
      if (ORDER == slice_tx_pkg::ORDER_LSB_FIRST) begin : g_lsb
         assign slices[s] = head[s*SW +: SW];
      end else begin : g_msb
         assign slices[s] = head[(LAST-s)*SW +: SW];
      end
   end

   assign cur_slice = empty ? '0 : slices[idx_q];
   assign slice_lo  = cur_slice[0];
   assign slice_hi  = cur_slice[1];

   // A read session starts at a strobe assertion with data waiting and ends
   // once the queue has drained.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         serving_q <= 1'b0;
      end else if (rd_rise && !empty) begin
         serving_q <= 1'b1;
      end else if (empty) begin
         serving_q <= 1'b0;
      end
   end

   slice_tx_tick #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable_i (irq_en),
      .ack_i    (rd_rise),
      .pend_o   (tick_pend)
   );

   assign irq = irq_en && (tick_pend || (!empty && !serving_q));

   // R3: the slice position only moves on a strobe release
   a_r3_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_fall |=> $stable(idx_q));

   // R4: releasing the last slice returns the position to the first slice
   a_r4_pop_wraps: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_fall && !empty && idx_q == IW'(LAST)) |=> (idx_q == '0));

   // R5: a strobe release with an empty queue leaves the position at zero
   a_r5_empty_idle: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> (idx_q == '0));

   // R7: a strobe assertion with data waiting silences the data request
   a_r7_ack_data: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_rise && !empty) |=> serving_q);

endmodule

// File: tb/slice_tx_port_tb.sv
module slice_tx_port_tb;

   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 4;
   localparam int TICK       = 600;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_valid = 1'b0;
   logic [7:0] wr_data = '0;
   logic       wr_ready;
   logic       host_rd = 1'b0;
   logic       irq_en = 1'b0;
   logic       slice_lo, slice_hi, byte_avail, irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   slice_tx_port #(
      .DATA_W(8), .DEPTH(DEPTH), .SYNC_STAGES(2), .TICK_CYCLES(TICK)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
      .wr_ready(wr_ready), .host_rd(host_rd), .irq_en(irq_en),
      .slice_lo(slice_lo), .slice_hi(slice_hi), .byte_avail(byte_avail),
      .irq(irq)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: got %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wait_clks(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic push(input logic [7:0] b);
      @(negedge clk);
      wr_valid = 1'b1;
      wr_data  = b;
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   task automatic strobe_on();
      @(negedge clk);
      host_rd = 1'b1;
      wait_clks(4);
   endtask

   task automatic strobe_off();
      @(negedge clk);
      host_rd = 1'b0;
      wait_clks(4);
   endtask

   task automatic read_byte(input string tag, input logic [7:0] exp);
      for (int k = 0; k < 4; k++) begin
         strobe_on();
         check(tag, {slice_hi, slice_lo}, exp[2*k +: 2]);
         strobe_off();
      end
   endtask

   task automatic t_reset();
      check("R1 byte_avail", byte_avail, 0);
      check("R1 irq", irq, 0);
      check("R1 slices", {slice_hi, slice_lo}, 0);
      check("R1 wr_ready", wr_ready, 1);
   endtask

   task automatic t_single();
      push(8'hA5);
      check("R2 avail after write", byte_avail, 1);
      check("R3 first slice before strobe", {slice_hi, slice_lo}, 2'b01);
      strobe_on();
      check("R3 slice during strobe", {slice_hi, slice_lo}, 2'b01);
      strobe_off();
      wait_clks(3);
      check("R3 slice held between strobes", {slice_hi, slice_lo}, 2'b01);
      for (int k = 1; k < 4; k++) begin
         strobe_on();
         check("R3 slice order", {slice_hi, slice_lo}, (8'hA5 >> (2*k)) & 3);
         strobe_off();
      end
      check("R4 avail low after last", byte_avail, 0);
      check("R2 slices zero when empty", {slice_hi, slice_lo}, 0);
   endtask

   task automatic t_back_to_back();
      push(8'h3C);
      push(8'hE1);
      read_byte("R3 first of pair", 8'h3C);
      check("R4 avail stays high", byte_avail, 1);
      check("R4 next byte slice0", {slice_hi, slice_lo}, 2'b01);
      read_byte("R3 second of pair", 8'hE1);
      check("R4 avail drops", byte_avail, 0);
   endtask

   task automatic t_empty_strobe();
      strobe_on(); strobe_off();
      strobe_on(); strobe_off();
      check("R5 still empty", byte_avail, 0);
      push(8'h96);
      check("R5 starts at slice0", {slice_hi, slice_lo}, 2'b10);
      read_byte("R5 full byte after idle strobes", 8'h96);
      check("R5 empty again", byte_avail, 0);
   endtask

   task automatic t_full();
      logic [7:0] vals [4] = '{8'h11, 8'h22, 8'h4B, 8'hD8};
      for (int i = 0; i < DEPTH; i++) push(vals[i]);
      check("R6 wr_ready low when full", wr_ready, 0);
      push(8'hFF);
      for (int i = 0; i < DEPTH; i++) read_byte("R6 order kept", vals[i]);
      check("R6 dropped write absent", byte_avail, 0);
      check("R6 wr_ready back", wr_ready, 1);
   endtask

   task automatic t_irq();
      push(8'h5A);
      wait_clks(3);
      check("R8 irq masked with data", irq, 0);
      @(negedge clk);
      irq_en = 1'b1;
      #1;
      check("R8 enable shows pending data", irq, 1);
      check("R7 irq with data", irq, 1);
      push(8'hC3);
      strobe_on();
      check("R7 irq drops on first strobe", irq, 0);
      check("R3 slice of irq byte", {slice_hi, slice_lo}, 2'b10);
      strobe_off();
      for (int k = 1; k < 4; k++) begin strobe_on(); strobe_off(); end
      check("R7 irq low while looping", irq, 0);
      check("R4 second byte waiting", byte_avail, 1);
      read_byte("R7 second byte data", 8'hC3);
      check("R7 irq low after drain", irq, 0);
      wait_clks(2);
      push(8'h07);
      check("R7 irq reasserts on new byte", irq, 1);
      read_byte("R7 third byte data", 8'h07);
      @(negedge clk);
      irq_en = 1'b0;
      wait_clks(2);
      check("R8 irq low after disable", irq, 0);
   endtask

   task automatic t_tick();
      @(negedge clk);
      irq_en = 1'b1;
      wait_clks(TICK / 2);
      check("R9 no tick early", irq, 0);
      wait_clks(TICK / 2 + 4);
      check("R9 tick irq", irq, 1);
      check("R9 no data with tick", byte_avail, 0);
      strobe_on();
      check("R9 strobe clears tick", irq, 0);
      strobe_off();
      check("R9 slices zero on tick", {slice_hi, slice_lo}, 0);
      wait_clks(TICK);
      check("R9 next tick", irq, 1);
      @(negedge clk);
      irq_en = 1'b0;
      wait_clks(TICK + 10);
      check("R8 ticks masked", irq, 0);
   endtask

   initial begin
      wait_clks(3);
      t_reset();
      rst_n = 1'b1;
      wait_clks(2);
      t_reset();
      t_single();
      t_back_to_back();
      t_empty_strobe();
      t_full();
      t_irq();
      t_tick();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: got %0h expected %0h", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

endmodule